// File: doc/BRIEF.md
# Three-Channel Doorbell Mailbox

This block is a mailbox between a local processor and one or more remote processors. It sits on an APB bus and offers three fixed channels. Each channel keeps a 32-bit word of doorbell flags. The sending side raises flags by writing ones to a set register. The receiving side reads the flag word and acknowledges by writing ones to a clear register. Each flag bit stands for a separate event. A sender learns that its message was consumed by polling the flag word until the receiver has cleared its bits.

Each channel drives one interrupt line. The line is high while any of the channel's 32 flags is set, and it comes from a register so that it cannot glitch. Channel 0 carries low-priority non-secure traffic and channel 1 carries high-priority non-secure traffic. Channel 2 is reserved for secure software: a non-secure access to it is refused with an error response, returns zero and changes nothing.

Top module: `dbell_mailbox`

## Requirements
- R1: After the asynchronous reset (rst_ni low), every flag word reads zero and all three interrupt outputs are low, including when reset is applied in the middle of a run.
- R2: A completed write to a channel's set register (offset 0x08) ORs the written data into that channel's flag word; flags that are already set stay set.
- R3: A completed write to a channel's clear register (offset 0x10) clears every flag whose data bit is one and leaves all other flags unchanged.
- R4: irq_o[n] is high exactly when channel n has at least one flag set. It changes on the same clock edge that updates the flags.
- R5: The channels are independent: a write to one channel changes no flag and no interrupt of another channel.
- R6: The channel bases are 0x000, 0x020 and 0x200. The flag word sits at base+0x00, the set register at base+0x08 and the clear register at base+0x10. The set and clear registers read back as zero.
- R7: When pprot_i[1] is 1 (non-secure), any access to a channel 2 register sets pslverr_o in the access phase, reads as zero and leaves the flags unchanged.
- R8: A secure access (pprot_i[1] = 0) to channel 2 works like an access to any other channel and reports no error.
- R9: pready_o is always 1, so every transfer completes with no wait states. Only the access phase (psel_i and penable_i both high) writes; a setup phase alone changes nothing.
- R10: An access to an address outside the nine mapped registers reads zero, reports no error and changes no flag.
- R11: A non-secure access to channel 0 or channel 1 reports no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | APB peripheral clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| psel_i | input | 1 | APB select |
| penable_i | input | 1 | APB enable (access phase) |
| pwrite_i | input | 1 | APB write when 1, read when 0 |
| paddr_i | input | 12 | Byte address within the 4 KB window |
| pwdata_i | input | 32 | Write data |
| pprot_i | input | 3 | APB protection; bit 1 = non-secure |
| prdata_o | output | 32 | Read data |
| pready_o | output | 1 | Transfer ready, always 1 |
| pslverr_o | output | 1 | Error response for refused secure-channel access |
| irq_o | output | 3 | Per-channel interrupt, bit n for channel n |

## Verification
The flag logic is tried with a single-bit pattern, a pattern on the top bit that must merge into flags already set, a partial clear that takes one bit out of several, and an all-ones pattern. The merge case shows OR behaviour apart from overwrite. The partial clear shows a bitwise clear apart from a whole-word clear. The all-ones write, sent non-secure to the secure channel and to an unmapped address, shows that the refusal and the address decode block every bit. Traffic that alternates between channels shows independence, and stepping the interrupts down from 111 to 000 one channel at a time shows the OR reduction.

// File: rtl/dbell_pkg.sv
package dbell_pkg;
  localparam int unsigned NUM_CH   = 3;
  localparam int unsigned SEC_CH   = 2;
  localparam int unsigned OFF_STAT = 32'h00;
  localparam int unsigned OFF_SET  = 32'h08;
  localparam int unsigned OFF_CLR  = 32'h10;

  // channel window bases: 0x000, 0x020, then 0x200 steps
  function automatic int unsigned ch_base(int unsigned idx);
    if (idx == 0)      return 32'h000;
    else if (idx == 1) return 32'h020;
    else               return 32'h200 * (idx - 1);
  endfunction
endpackage

// File: rtl/dbell_apb_decode.sv
module dbell_apb_decode
  import dbell_pkg::*;
#(
  parameter int unsigned ADDR_W = 12,
  parameter int unsigned N_CH   = NUM_CH,
  parameter int unsigned S_CH   = SEC_CH
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              psel_i,
  input  logic              penable_i,
  input  logic              pwrite_i,
  input  logic [ADDR_W-1:0] paddr_i,
  input  logic [2:0]        pprot_i,
  output logic [N_CH-1:0]   set_we_o,
  output logic [N_CH-1:0]   clr_we_o,
  output logic [N_CH-1:0]   rd_sel_o,
  output logic              deny_o
);
  localparam int unsigned WA = ADDR_W - 2;

  logic            access;
  logic            nonsec;
  logic [N_CH-1:0] deny_c;
  logic            unused_bits;

  assign access      = psel_i & penable_i;
  assign nonsec      = pprot_i[1];
  assign unused_bits = ^{pprot_i[2], pprot_i[0], paddr_i[1:0]};

  for (genvar g = 0; g < N_CH; g++) begin : g_ch
    localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(ch_base(g) + OFF_STAT);
    localparam logic [ADDR_W-1:0] A_SET  = ADDR_W'(ch_base(g) + OFF_SET);
    localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(ch_base(g) + OFF_CLR);

    logic hit_stat, hit_set, hit_clr, blocked;

    assign hit_stat = paddr_i[ADDR_W-1:2] == A_STAT[ADDR_W-1:2];
    assign hit_set  = paddr_i[ADDR_W-1:2] == A_SET[ADDR_W-1:2];
    assign hit_clr  = paddr_i[ADDR_W-1:2] == A_CLR[ADDR_W-1:2];

    if (g == S_CH) begin : g_sec
      assign blocked = nonsec & (hit_stat | hit_set | hit_clr);
    end else begin : g_open
      assign blocked = 1'b0;
    end

    assign deny_c[g]   = blocked;
    assign set_we_o[g] = access & pwrite_i & hit_set & ~blocked;
    assign clr_we_o[g] = access & pwrite_i & hit_clr & ~blocked;
    assign rd_sel_o[g] = psel_i & ~pwrite_i & hit_stat & ~blocked;
  end

  assign deny_o = access & (|deny_c);

  AST_ONE_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({set_we_o, clr_we_o})) else $error("strobe overlap"); // R6
  AST_NO_SETUP_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(psel_i && penable_i) |-> (set_we_o == '0 && clr_we_o == '0)) else $error("setup wr"); // R9
  AST_RD_ONEHOT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(rd_sel_o)) else $error("read select overlap"); // R6
  if (WA < 2) begin : g_bad_w
    initial $error("address too narrow");
  end
endmodule

// File: rtl/dbell_channel.sv
module dbell_channel #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              set_we_i,
  input  logic              clr_we_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] stat_o,
  output logic              irq_o
);
  logic [DATA_W-1:0] stat_q, stat_d, set_mask, clr_mask;
  logic              irq_q;

  assign set_mask = set_we_i ? wdata_i : '0;
  assign clr_mask = clr_we_i ? wdata_i : '0;
  // clear wins over set on overlapping bits
  assign stat_d   = (stat_q | set_mask) & ~clr_mask;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q <= '0;
      irq_q  <= 1'b0;
    end else begin
      stat_q <= stat_d;
      irq_q  <= |stat_d;
    end
  end

  assign stat_o = stat_q;
  assign irq_o  = irq_q;

  AST_IRQ_OR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o == (|stat_o)) else $error("irq mismatch"); // R4
  AST_SET_STICKS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_we_i && !clr_we_i) |=> ((stat_o & $past(wdata_i)) == $past(wdata_i))) else $error("set lost"); // R2
  AST_SET_KEEPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_we_i && !clr_we_i) |=> ((stat_o & $past(stat_o)) == $past(stat_o))) else $error("set dropped bits"); // R2
  AST_CLR_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_we_i |=> ((stat_o & $past(wdata_i)) == '0)) else $error("clear failed"); // R3
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!set_we_i && !clr_we_i) |=> $stable(stat_o)) else $error("flags moved"); // R5
endmodule

// File: rtl/dbell_rd_mux.sv
module dbell_rd_mux #(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned N_CH   = 3
) (
  input  logic [N_CH-1:0]             sel_i,
  input  logic [N_CH-1:0][DATA_W-1:0] data_i,
  output logic [DATA_W-1:0]           data_o
);
  always_comb begin
    data_o = '0;
    for (int i = 0; i < N_CH; i++) begin
      if (sel_i[i]) data_o = data_o | data_i[i];
    end
  end
endmodule

// File: rtl/dbell_mailbox.sv
module dbell_mailbox
  import dbell_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              psel_i,
  input  logic              penable_i,
  input  logic              pwrite_i,
  input  logic [ADDR_W-1:0] paddr_i,
  input  logic [DATA_W-1:0] pwdata_i,
  input  logic [2:0]        pprot_i,
  output logic [DATA_W-1:0] prdata_o,
  output logic              pready_o,
  output logic              pslverr_o,
  output logic [NUM_CH-1:0] irq_o
);
  localparam logic [ADDR_W-1:0] SEC_STAT = ADDR_W'(ch_base(SEC_CH) + OFF_STAT);

  logic [NUM_CH-1:0]             set_we, clr_we, rd_sel;
  logic [NUM_CH-1:0][DATA_W-1:0] stat_w;
  logic                          deny;

  dbell_apb_decode #(
    .ADDR_W(ADDR_W), .N_CH(NUM_CH), .S_CH(SEC_CH)
  ) u_decode (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .psel_i    (psel_i),
    .penable_i (penable_i),
    .pwrite_i  (pwrite_i),
    .paddr_i   (paddr_i),
    .pprot_i   (pprot_i),
    .set_we_o  (set_we),
    .clr_we_o  (clr_we),
    .rd_sel_o  (rd_sel),
    .deny_o    (deny)
  );

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
    dbell_channel #(.DATA_W(DATA_W)) u_chan (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .set_we_i (set_we[g]),
      .clr_we_i (clr_we[g]),
      .wdata_i  (pwdata_i),
      .stat_o   (stat_w[g]),
      .irq_o    (irq_o[g])
    );
  end

  dbell_rd_mux #(.DATA_W(DATA_W), .N_CH(NUM_CH)) u_rd_mux (
    .sel_i  (rd_sel),
    .data_i (stat_w),
    .data_o (prdata_o)
  );

  assign pready_o  = 1'b1;
  assign pslverr_o = deny;

  AST_SEC_ERR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (psel_i && penable_i && pprot_i[1] && paddr_i[ADDR_W-1:2] == SEC_STAT[ADDR_W-1:2])
    |-> pslverr_o) else $error("secure read not refused"); // R7
  AST_SEC_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pslverr_o |=> $stable(stat_w[SEC_CH])) else $error("refused write landed"); // R7
  AST_SEC_RD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pslverr_o |-> prdata_o == '0) else $error("refused read leaked"); // R7
  AST_SECURE_OK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pprot_i[1] |-> !pslverr_o) else $error("secure access refused"); // R8
endmodule

// File: tb/dbell_mailbox_bench.sv
module dbell_mailbox_bench;
  localparam int unsigned DW = 32;
  localparam int unsigned AW = 12;
  localparam logic [2:0] NS = 3'b010;
  localparam logic [2:0] SC = 3'b000;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [AW-1:0] paddr = '0;
  logic [DW-1:0] pwdata = '0;
  logic [2:0]    pprot = SC;
  logic [DW-1:0] prdata;
  logic          pready, pslverr;
  logic [2:0]    irq;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  always #2.5 clk = ~clk;

  dbell_mailbox u_dbell_mailbox (
    .clk_i(clk), .rst_ni(rst_n), .psel_i(psel), .penable_i(penable),
    .pwrite_i(pwrite), .paddr_i(paddr), .pwdata_i(pwdata), .pprot_i(pprot),
    .prdata_o(prdata), .pready_o(pready), .pslverr_o(pslverr), .irq_o(irq)
  );

  typedef struct packed {
    logic        wr;
    logic [11:0] addr;
    logic [2:0]  prot;
    logic [31:0] wd;
    logic [31:0] rd;
    logic        err;
    logic [2:0]  irq;
    logic [7:0]  req;
  } vec_t;

  localparam int NV = 25;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 12'h008, NS, 32'h0000_0011, 32'h0, 1'b0, 3'b001, 8'd2},  // R2 R11
    '{1'b0, 12'h000, NS, 32'h0,         32'h0000_0011, 1'b0, 3'b001, 8'd2},
    '{1'b1, 12'h008, NS, 32'h8000_0000, 32'h0, 1'b0, 3'b001, 8'd2},  // R2 merge
    '{1'b0, 12'h000, NS, 32'h0,         32'h8000_0011, 1'b0, 3'b001, 8'd2},
    '{1'b1, 12'h010, NS, 32'h0000_0001, 32'h0, 1'b0, 3'b001, 8'd3},  // R3
    '{1'b0, 12'h000, NS, 32'h0,         32'h8000_0010, 1'b0, 3'b001, 8'd3},
    '{1'b1, 12'h028, NS, 32'h0000_0F00, 32'h0, 1'b0, 3'b011, 8'd5},  // R5
    '{1'b0, 12'h020, NS, 32'h0,         32'h0000_0F00, 1'b0, 3'b011, 8'd5},
    '{1'b0, 12'h000, NS, 32'h0,         32'h8000_0010, 1'b0, 3'b011, 8'd5},
    '{1'b1, 12'h208, NS, 32'hFFFF_FFFF, 32'h0, 1'b1, 3'b011, 8'd7},  // R7
    '{1'b0, 12'h200, NS, 32'h0,         32'h0, 1'b1, 3'b011, 8'd7},
    '{1'b0, 12'h200, SC, 32'h0,         32'h0, 1'b0, 3'b011, 8'd7},
    '{1'b1, 12'h208, SC, 32'h0000_0005, 32'h0, 1'b0, 3'b111, 8'd8},  // R8
    '{1'b0, 12'h200, SC, 32'h0,         32'h0000_0005, 1'b0, 3'b111, 8'd8},
    '{1'b1, 12'h210, NS, 32'h0000_0005, 32'h0, 1'b1, 3'b111, 8'd7},  // R7 clear refused
    '{1'b0, 12'h200, SC, 32'h0,         32'h0000_0005, 1'b0, 3'b111, 8'd7},
    '{1'b0, 12'h008, NS, 32'h0,         32'h0, 1'b0, 3'b111, 8'd6},  // R6
    '{1'b0, 12'h010, NS, 32'h0,         32'h0, 1'b0, 3'b111, 8'd6},
    '{1'b1, 12'h040, NS, 32'hFFFF_FFFF, 32'h0, 1'b0, 3'b111, 8'd10}, // R10
    '{1'b0, 12'h040, NS, 32'h0,         32'h0, 1'b0, 3'b111, 8'd10},
    '{1'b0, 12'h000, NS, 32'h0,         32'h8000_0010, 1'b0, 3'b111, 8'd10},
    '{1'b1, 12'h010, NS, 32'h8000_0010, 32'h0, 1'b0, 3'b110, 8'd4},  // R4
    '{1'b1, 12'h030, NS, 32'h0000_0F00, 32'h0, 1'b0, 3'b100, 8'd4},
    '{1'b1, 12'h210, SC, 32'h0000_0005, 32'h0, 1'b0, 3'b000, 8'd4},
    '{1'b0, 12'h020, NS, 32'h0,         32'h0, 1'b0, 3'b000, 8'd4}
  };

  task automatic chk(input string what, input int req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL R%0d %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // one APB transfer; returns read data and error from the access phase
  task automatic xfer(input logic wr, input logic [AW-1:0] a, input logic [2:0] prot,
                      input logic [DW-1:0] wd, output logic [DW-1:0] rd, output logic err);
    @(negedge clk);
    psel = 1'b1; penable = 1'b0; pwrite = wr; paddr = a; pprot = prot; pwdata = wd;
    @(negedge clk);
    penable = 1'b1;
    #1;
    chk("pready", 9, 32'(pready), 32'h1); // R9
    rd  = prdata;
    err = pslverr;
    @(negedge clk);
    psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    #1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog R9: actual=timeout expected=completion");
    finish_run();
  end

  initial begin : main
    logic [DW-1:0] rd;
    logic          err;

    repeat (3) @(negedge clk);
    #1;
    chk("irq in reset", 1, 32'(irq), 32'h0); // R1
    @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state of every flag word
    xfer(1'b0, 12'h000, NS, '0, rd, err); chk("ch0 after reset", 1, rd, 32'h0);
    xfer(1'b0, 12'h020, NS, '0, rd, err); chk("ch1 after reset", 1, rd, 32'h0);
    xfer(1'b0, 12'h200, SC, '0, rd, err); chk("ch2 after reset", 1, rd, 32'h0);
    chk("irq after reset", 1, 32'(irq), 32'h0);

    // main table
    for (int i = 0; i < NV; i++) begin
      xfer(VECS[i].wr, VECS[i].addr, VECS[i].prot, VECS[i].wd, rd, err);
      chk($sformatf("vec%0d pslverr", i), VECS[i].req, 32'(err), 32'(VECS[i].err));
      if (!VECS[i].wr)
        chk($sformatf("vec%0d prdata", i), VECS[i].req, rd, VECS[i].rd);
      chk($sformatf("vec%0d irq", i), VECS[i].req, 32'(irq), 32'(VECS[i].irq));
    end

    // R9: setup phase held without enable must not write
    @(negedge clk);
    psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = 12'h008; pprot = NS; pwdata = 32'h0000_00F0;
    repeat (3) @(negedge clk);
    psel = 1'b0; pwrite = 1'b0;
    #1;
    chk("setup-only irq", 9, 32'(irq), 32'h0); // R9
    xfer(1'b0, 12'h000, NS, '0, rd, err); chk("setup-only flags", 9, rd, 32'h0);

    // R3 clear of zero bits is harmless; R2 all-ones set
    xfer(1'b1, 12'h028, NS, 32'hFFFF_FFFF, rd, err);
    xfer(1'b1, 12'h030, NS, 32'h0000_0000, rd, err);
    xfer(1'b0, 12'h020, NS, '0, rd, err); chk("zero clear keeps", 3, rd, 32'hFFFF_FFFF);
    xfer(1'b1, 12'h030, NS, 32'h7FFF_FFFF, rd, err);
    chk("top bit holds irq", 4, 32'(irq), 32'h2); // R4
    xfer(1'b0, 12'h020, NS, '0, rd, err); chk("partial clear", 3, rd, 32'h8000_0000);

    // R1: mid-run asynchronous reset
    xfer(1'b1, 12'h008, NS, 32'h0000_0003, rd, err);
    xfer(1'b1, 12'h208, SC, 32'h0000_0100, rd, err);
    chk("irq before reset", 1, 32'(irq), 32'h7);
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk("irq async reset", 1, 32'(irq), 32'h0);
    @(negedge clk);
    rst_n = 1'b1;
    xfer(1'b0, 12'h000, NS, '0, rd, err); chk("ch0 after mid reset", 1, rd, 32'h0);
    xfer(1'b0, 12'h020, NS, '0, rd, err); chk("ch1 after mid reset", 1, rd, 32'h0);
    xfer(1'b0, 12'h200, SC, '0, rd, err); chk("ch2 after mid reset", 1, rd, 32'h0);

    finish_run();
  end
endmodule